// File: doc/BRIEF.md
# SDRAM Command Issuer

This block sits between a software-visible command register and the SDRAM sequencing logic of a memory controller. Software writes one 32-bit word that holds a command code, two bank-target bits, a refresh repeat count and a 14-bit mode-register value. The block checks the word against the bank-targeting rules. A legal word is latched and turned into single-cycle command strobes toward one or both SDRAM banks. An illegal word is dropped with no trace.

The two banks share the command code and the mode-register payload. Each bank has its own strobe. An auto-refresh request becomes a counted run of refresh strobes, spaced by a parameterised refresh-cycle time. While a command or a refresh run is in flight the block reports busy. Any write that arrives during that time is refused and flagged with a one-cycle error pulse. A static input tells the block whether one bank or two banks are fitted. The last accepted word can always be read back.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset the read-back word is all zeros. An accepted write stores bits [22:0] of the word, and bits [31:23] always read back as zero.
- R2: Bit 4 of the word targets bank 1 and drives `bank_stb[0]`. Bit 3 targets bank 2 and drives `bank_stb[1]`. An accepted command strobes exactly the targeted banks.
- R3: A word with both target bits clear is ignored. No strobe fires, busy stays low and the read-back word is unchanged.
- R4: With `two_banks` high, auto-refresh (code 3'b011 in bits [2:0]) and precharge-all (code 3'b010) must set both target bits. If only one is set, the word is ignored.
- R5: With `two_banks` low, a word with bit 3 set is ignored.
- R6: Code 3'b111 is reserved, and a word carrying it is ignored.
- R7: Auto-refresh produces (bits [8:5] + 1) strobes, so a run is 1 to 16 strobes long. Successive strobes are exactly `TRFC` cycles apart.
- R8: Whenever a strobe is high, `cmd_code` equals the stored bits [2:0] and `mode_payload` equals the stored bits [22:9]. The codes are 0 normal, 1 clock-enable, 2 precharge-all, 3 auto-refresh, 4 load-mode, 5 self-refresh and 6 power-down.
- R9: `busy` is high from the first strobe cycle through the last strobe cycle of a command. A write that is sampled while busy is high is dropped, leaves the stored word unchanged, and raises `err_pulse` in the next cycle.
- R10: The first strobe appears in the cycle right after the clock edge that accepts the write. Commands other than auto-refresh give one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Command word being written |
| two_banks | input | 1 | Static: 1 = two banks fitted, 0 = only bank 1 |
| rd_data | output | 32 | Last accepted command word |
| bank_stb | output | 2 | Per-bank command strobe, [0] bank 1, [1] bank 2 |
| cmd_code | output | 3 | Command code shared by both banks |
| mode_payload | output | 14 | Mode-register value shared by both banks |
| busy | output | 1 | Command or refresh run in progress |
| err_pulse | output | 1 | One-cycle pulse after a write refused while busy |

## Verification
The bench targets the shortest and longest refresh runs, where an off-by-one in the count gives 0 or 17 strobes, or a spacing that is one cycle short. It sends single-target refresh and precharge-all words in two-bank mode, and bank-2 words in one-bank mode. A design that misses these checks would strobe a bank that must stay idle and overwrite the read-back word. Writes landing in the first cycle of busy check that a refused write neither restarts the run nor corrupts the stored word, and that it raises the error pulse.

// File: rtl/sdci_pkg.sv
package sdci_pkg;
  localparam int WORD_W   = 32;
  localparam int CODE_W   = 3;
  localparam int CNT_W    = 4;
  localparam int MRV_W    = 14;
  localparam int KEEP_W   = 23;
  localparam int B2_POS   = 3;
  localparam int B1_POS   = 4;
  localparam int CNT_LSB  = 5;
  localparam int MRV_LSB  = 9;

  typedef enum logic [CODE_W-1:0] {
    CMD_NORMAL = 3'd0,
    CMD_CKE    = 3'd1,
    CMD_PALL   = 3'd2,
    CMD_AREF   = 3'd3,
    CMD_LMR    = 3'd4,
    CMD_SELF   = 3'd5,
    CMD_PDOWN  = 3'd6,
    CMD_RSVD   = 3'd7
  } cmd_e;

  // Legality of a command given its targets ({bank2,bank1}) and bank setup
  function automatic logic cmd_legal(input logic [CODE_W-1:0] code,
                                     input logic [1:0] tgt,
                                     input logic dual);
    logic ok;
    ok = (tgt != 2'b00) && (code != CMD_RSVD);
    if (!dual && tgt[1]) ok = 1'b0;
    if (dual && (code == CMD_AREF || code == CMD_PALL) && tgt != 2'b11) ok = 1'b0;
    return ok;
  endfunction

  // Strobes remaining after the first one
  function automatic logic [CNT_W-1:0] extra_strobes(input logic [CODE_W-1:0] code,
                                                      input logic [CNT_W-1:0] cnt);
    return (code == CMD_AREF) ? cnt : '0;
  endfunction
endpackage

// File: rtl/sdci_decode.sv
module sdci_decode
  import sdci_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              dual,
  output logic              legal,
  output logic [CNT_W-1:0]  extra
);
  logic [CODE_W-1:0] code;
  logic [1:0]        tgt;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    code  = word[CODE_W-1:0];
    tgt   = {word[B2_POS], word[B1_POS]};
    cnt   = word[CNT_LSB +: CNT_W];
    legal = cmd_legal(code, tgt, dual);
    extra = extra_strobes(code, cnt);
  end
endmodule

// File: rtl/sdci_store.sv
module sdci_store
  import sdci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= {{(WORD_W-KEEP_W){1'b0}}, din[KEEP_W-1:0]};
  end
endmodule

// File: rtl/sdci_seq.sv
module sdci_seq
  import sdci_pkg::*;
#(
  parameter int TRFC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] extra,
  output logic             active,
  output logic             fire
);
  localparam int GW = (TRFC > 1) ? $clog2(TRFC) : 1;

  logic [CNT_W-1:0] rem_q;
  logic [GW-1:0]    gap_q;

  assign fire = active && (gap_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem_q  <= '0;
      gap_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      rem_q  <= extra;
      gap_q  <= '0;
    end else if (active) begin
      if (gap_q == '0) begin
        if (rem_q == '0) begin
          active <= 1'b0;
        end else begin
          rem_q <= rem_q - 1'b1;
          gap_q <= GW'(TRFC - 1);
        end
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdci_pkg::*;
#(
  parameter int TRFC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        two_banks,
  output logic [31:0] rd_data,
  output logic [1:0]  bank_stb,
  output logic [2:0]  cmd_code,
  output logic [13:0] mode_payload,
  output logic        busy,
  output logic        err_pulse
);
  logic             legal;
  logic [CNT_W-1:0] extra;
  logic             accept;
  logic             refused;
  logic             fire;
  logic             active;
  logic             err_q;

  sdci_decode u_dec (
    .word  (wr_data),
    .dual  (two_banks),
    .legal (legal),
    .extra (extra)
  );

  assign accept  = wr_en && !active && legal;
  assign refused = wr_en && active;

  sdci_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .din    (wr_data),
    .word_q (rd_data)
  );

  sdci_seq #(.TRFC(TRFC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .extra  (extra),
    .active (active),
    .fire   (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= refused;
  end

  assign bank_stb     = {fire & rd_data[B2_POS], fire & rd_data[B1_POS]};
  assign cmd_code     = rd_data[CODE_W-1:0];
  assign mode_payload = rd_data[MRV_LSB +: MRV_W];
  assign busy         = active;
  assign err_pulse    = err_q;
endmodule

// File: rtl/sdci_chk.sv
module sdci_chk #(
  parameter int TRFC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        two_banks,
  input logic [31:0] rd_data,
  input logic [1:0]  bank_stb,
  input logic [2:0]  cmd_code,
  input logic [13:0] mode_payload,
  input logic        busy,
  input logic        err_pulse,
  input logic        accept
);
  localparam int SW = $clog2(TRFC + 2);

  logic [4:0]    run_cnt;
  logic [SW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (!busy) run_cnt <= '0;
      else if (|bank_stb) run_cnt <= run_cnt + 1'b1;
      if (!busy) seen_q <= 1'b0;
      else if (|bank_stb) seen_q <= 1'b1;
      if (|bank_stb) since_q <= SW'(1);
      else if (since_q < SW'(TRFC + 1)) since_q <= since_q + 1'b1;
    end
  end

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:23] == 9'd0);
  // R2
  target_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bank_stb == {$past(wr_data[3]), $past(wr_data[4])});
  // R3
  no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && wr_data[4:3] == 2'b00 |=> !busy && $stable(rd_data));
  // R4
  dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    two_banks && (|bank_stb) && (cmd_code == 3'd3 || cmd_code == 3'd2) |-> bank_stb == 2'b11);
  // R5
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !two_banks && wr_en && !busy && wr_data[3] |=> !busy && $stable(rd_data));
  // R6
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && wr_data[2:0] == 3'd7 |=> !busy && $stable(rd_data));
  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && cmd_code == 3'd3 |-> run_cnt == {1'b0, rd_data[8:5]} + 5'd1);
  // R7
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_stb) && seen_q |-> since_q == SW'(TRFC));
  // R8
  payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_stb) |-> cmd_code == rd_data[2:0] && mode_payload == rd_data[22:9]);
  // R9
  stb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_stb) |-> busy);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> err_pulse && $stable(rd_data));
  // R10
  first_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (|bank_stb));
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_stb) && cmd_code != 3'd3 |=> !(|bank_stb));
endmodule

bind sdram_cmd_issuer sdci_chk #(.TRFC(TRFC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .two_banks    (two_banks),
  .rd_data      (rd_data),
  .bank_stb     (bank_stb),
  .cmd_code     (cmd_code),
  .mode_payload (mode_payload),
  .busy         (busy),
  .err_pulse    (err_pulse),
  .accept       (accept)
);

// File: tb/sdram_cmd_issuer_test.sv
module sdram_cmd_issuer_test;
  localparam int T = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        two_banks = 1'b1;
  logic [31:0] rd_data;
  logic [1:0]  bank_stb;
  logic [2:0]  cmd_code;
  logic [13:0] mode_payload;
  logic        busy;
  logic        err_pulse;

  int tests = 0;
  int fails = 0;
  logic [31:0] model_word = '0;

  always #2.5 clk = ~clk;

  sdram_cmd_issuer #(.TRFC(T)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .two_banks(two_banks), .rd_data(rd_data), .bank_stb(bank_stb),
    .cmd_code(cmd_code), .mode_payload(mode_payload), .busy(busy),
    .err_pulse(err_pulse)
  );

  // Bench view of the acceptance rules (R3, R4, R5, R6)
  function automatic bit ok_word(input logic [31:0] w, input bit dual);
    bit b1, b2;
    b1 = w[4];
    b2 = w[3];
    case (w[2:0])
      3'd7:       return 1'b0;
      3'd2, 3'd3: if (dual) return b1 & b2;
                  else      return b1 & !b2;
      default:    if (dual) return b1 | b2;
                  else      return b1 & !b2;
    endcase
  endfunction

  function automatic int strobes_for(input logic [31:0] w);
    return (w[2:0] == 3'd3) ? int'(w[8:5]) + 1 : 1;
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one word and follow it until the run is over
  task automatic issue(input logic [31:0] w, input string req);
    bit   legal;
    int   n, win, bad;
    logic [1:0] exp_stb;
    logic [31:0] bad_act, bad_exp;
    legal = ok_word(w, two_banks);
    n     = strobes_for(w);
    win   = legal ? (n - 1) * T + 3 : 3;
    bad = 0; bad_act = '0; bad_exp = '0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (legal) model_word = {9'd0, w[22:0]};
    for (int k = 0; k < win; k++) begin
      if (k > 0) @(negedge clk);
      exp_stb = (legal && (k % T == 0) && (k / T < n)) ? {w[3], w[4]} : 2'b00;
      if (bank_stb !== exp_stb || busy !== (legal && k <= (n - 1) * T) || err_pulse !== 1'b0) begin
        if (bad == 0) begin
          bad_act = {24'd0, k[3:0], bank_stb, busy, err_pulse};
          bad_exp = {24'd0, k[3:0], exp_stb, (legal && k <= (n - 1) * T), 1'b0};
        end
        bad++;
      end
      if (exp_stb != 2'b00 && (cmd_code !== w[2:0] || mode_payload !== w[22:9])) begin
        if (bad == 0) begin
          bad_act = {15'd0, mode_payload, cmd_code};
          bad_exp = {15'd0, w[22:9], w[2:0]};
        end
        bad++;
      end
    end
    report(bad == 0, req, "strobe/busy sequence", bad_act, bad_exp);
    report(rd_data === model_word, "R1", "read-back word", rd_data, model_word);
  endtask

  // Refresh run with a second write landing while busy (R9)
  task automatic busy_write(input logic [31:0] first, input logic [31:0] second);
    int n, stb_seen;
    n = strobes_for(first);
    @(negedge clk);
    wr_en = 1'b1; wr_data = first;
    @(posedge clk);
    @(negedge clk);
    wr_data = second;
    model_word = {9'd0, first[22:0]};
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    report(err_pulse === 1'b1, "R9", "error pulse after busy write", {31'd0, err_pulse}, 32'd1);
    stb_seen = 1;
    for (int k = 1; k < (n - 1) * T + 4; k++) begin
      if (k > 1) @(negedge clk);
      if (|bank_stb) stb_seen++;
    end
    report(stb_seen == n, "R9", "run not restarted by refused write", stb_seen, n);
    report(rd_data === model_word, "R9", "refused write left word alone", rd_data, model_word);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int unused;
    unused = $urandom(32'h5D0C_A11E);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report(rd_data === 32'd0, "R1", "reset word", rd_data, 32'd0);
    report({bank_stb, busy, err_pulse} === 4'd0, "R1", "reset outputs",
           {28'd0, bank_stb, busy, err_pulse}, 32'd0);

    // directed corners, two banks
    two_banks = 1'b1;
    issue(32'hFF80_0003 | (32'd0 << 5) | 32'h18, "R7");       // 1 refresh, upper bits set
    issue(32'h0000_0003 | (32'd15 << 5) | 32'h18, "R7");      // 16 refreshes
    issue(32'h0000_0003 | (32'd4 << 5) | 32'h10, "R4");       // refresh, bank1 only
    issue(32'h0000_0002 | 32'h08, "R4");                      // precharge-all, bank2 only
    issue(32'h0000_0002 | 32'h18, "R2");
    issue(32'h0000_0004 | (32'h2A5C << 9) | 32'h08, "R8");    // load mode, bank2 only
    issue(32'h0000_0005 | (32'h1234 << 9), "R3");             // no target
    issue(32'h0000_0007 | 32'h18, "R6");                      // reserved
    issue(32'h0000_0001 | 32'h10, "R10");
    busy_write(32'h0000_0003 | (32'd2 << 5) | 32'h18, 32'h0000_0004 | (32'h3FFF << 9) | 32'h18);

    // one bank
    two_banks = 1'b0;
    issue(32'h0000_0006 | 32'h08, "R5");                      // bank2 bit in one-bank mode
    issue(32'h0000_0002 | 32'h18, "R5");
    issue(32'h0000_0003 | (32'd3 << 5) | 32'h10, "R7");
    issue(32'h0000_0002 | 32'h10, "R10");

    // constrained random
    for (int i = 0; i < 80; i++) begin
      if (i % 20 == 0) two_banks = $urandom_range(0, 1);
      w = $urandom;
      if ($urandom_range(0, 3) != 0) w[4:3] = two_banks ? 2'b11 : 2'b10;
      issue(w, "R2");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule